// File: doc/BRIEF.md
# Dual Periodic Interval Interrupt Generator

This block raises two periodic interrupt requests from one free-running time base. A clock prescaler divides the system clock by `CLKS_PER_US` to give a one-cycle tick once per microsecond. A single microsecond counter, `LONG_LOG2` bits wide, advances on that tick. The short request fires each time the counter's low `SHORT_LOG2` bits roll over, which is every 1024 microseconds by default. The long request fires each time the whole counter rolls over, which is every 16384 microseconds by default.

Each request has one control input that serves as both enable and acknowledge. While the control input is 1, the request can be raised, and once raised it stays high. Driving the control input to 0 drops any pending request and blocks new ones. Software services an interrupt by writing its control bit to 0 and then back to 1. The time base never stops, so re-arming a channel does not restart its period. The next request arrives at the next boundary of the shared counter.

Top module: `dual_interval_irq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, both request outputs are 0. Reset clears the prescaler and the microsecond counter to 0.
- R2: The microsecond tick is one clock cycle wide and occurs once every `CLKS_PER_US` clock cycles. The first tick comes `CLKS_PER_US` cycles after reset is released.
- R3: With `short_en` at 1, `short_req` rises in the cycle after the tick on which the counter's low `SHORT_LOG2` bits are all ones. Counting rising edges after reset release from 1, these are the edges that are multiples of `CLKS_PER_US * 2**SHORT_LOG2`. By default that is one request every 1024 microseconds.
- R4: With `long_en` at 1, `long_req` rises in the cycle after the tick on which all `LONG_LOG2` counter bits are ones. These are the edges that are multiples of `CLKS_PER_US * 2**LONG_LOG2`. By default that is one request every 16384 microseconds.
- R5: A raised request stays at 1 for as long as its enable stays at 1.
- R6: An enable at 0 on a clock edge leaves that request at 0 after the edge. This holds even when a boundary occurs on the same edge, so clearing wins over raising.
- R7: The counter runs whatever the enables are. A channel enabled in the middle of a period requests at the next boundary, not a full period after it is enabled.
- R8: Every long boundary is also a short boundary. When both channels are enabled and neither is pending, both requests rise in the same cycle.
- R9: The two channels are independent. Enabling, clearing or raising one never changes the other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| short_en | input | 1 | Short channel arm (1) / disable and acknowledge (0) |
| long_en | input | 1 | Long channel arm (1) / disable and acknowledge (0) |
| short_req | output | 1 | Sticky short-period interrupt request |
| long_req | output | 1 | Sticky long-period interrupt request |

## Verification
The properties assume the enable inputs are synchronous to `clk` and stable around each rising edge, and that `SHORT_LOG2` does not exceed `LONG_LOG2`. The stimulus changes enables only on falling edges. The bench overrides the parameters to a two-cycle microsecond and 16- and 64-microsecond periods, so that boundaries are reached in a few hundred cycles. Enable changes are placed just before boundaries, just after them, and exactly on them, to exercise R6 and R7.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum int unsigned {
        CH_SHORT = 0,
        CH_LONG  = 1
    } irq_ch_e;

    localparam int unsigned NUM_CH = 2;

    function automatic int unsigned ch_bits(input int unsigned ch,
                                            input int unsigned short_log2,
                                            input int unsigned long_log2);
        return (ch == CH_SHORT) ? short_log2 : long_log2;
    endfunction
endpackage

// File: rtl/irq_us_prescaler.sv
module irq_us_prescaler #(
    parameter int unsigned CLKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(CLKS_PER_US - 1);

    typedef struct packed {
        logic [PRE_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.div == LAST);
        if (tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irq_us_counter.sv
module irq_us_counter
    import irq_pkg::*;
#(
    parameter int unsigned SHORT_LOG2 = 10,
    parameter int unsigned LONG_LOG2  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [NUM_CH-1:0] wrap
);
    typedef struct packed {
        logic [LONG_LOG2-1:0] us;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.us = st_q.us + 1'b1;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_wrap
        localparam int unsigned BITS = ch_bits(ch, SHORT_LOG2, LONG_LOG2);
        assign wrap[ch] = tick && (&st_q.us[BITS-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic evt,
    output logic req
);
    typedef struct packed {
        logic pend;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!arm) begin
            st_d.pend = 1'b0;
        end else if (evt) begin
            st_d.pend = 1'b1;
        end
    end

    assign req = st_q.pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dual_interval_irq.sv
module dual_interval_irq
    import irq_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 125,
    parameter int unsigned SHORT_LOG2  = 10,
    parameter int unsigned LONG_LOG2   = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic short_en,
    input  logic long_en,
    output logic short_req,
    output logic long_req
);
    logic              tick;
    logic [NUM_CH-1:0] wrap;
    logic [NUM_CH-1:0] arm_v;
    logic [NUM_CH-1:0] req_v;
    logic              short_evt;
    logic              long_evt;

    assign arm_v[CH_SHORT] = short_en;
    assign arm_v[CH_LONG]  = long_en;
    assign short_evt       = wrap[CH_SHORT];
    assign long_evt        = wrap[CH_LONG];

    irq_us_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    irq_us_counter #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wrap  (wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        irq_req_latch u_req (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (arm_v[ch]),
            .evt   (wrap[ch]),
            .req   (req_v[ch])
        );
    end

    assign short_req = req_v[CH_SHORT];
    assign long_req  = req_v[CH_LONG];
endmodule

// File: rtl/dual_interval_irq_chk.sv
module dual_interval_irq_chk #(
    parameter int unsigned CLKS_PER_US = 125
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic short_evt,
    input logic long_evt,
    input logic short_en,
    input logic long_en,
    input logic short_req,
    input logic long_req
);
    int unsigned gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == CLKS_PER_US - 1)); // R2
    AST_TICK_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q < CLKS_PER_US)); // R2
    AST_SHORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !short_en |=> !short_req); // R6
    AST_LONG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !long_en |=> !long_req); // R6
    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (short_req && short_en) |=> short_req); // R5
    AST_LONG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (long_req && long_en) |=> long_req); // R5
    AST_SHORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_req) |-> $past(short_evt && short_en)); // R3
    AST_LONG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_req) |-> $past(long_evt && long_en)); // R4
    AST_LONG_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
        long_evt |-> short_evt); // R8
endmodule

bind dual_interval_irq dual_interval_irq_chk #(.CLKS_PER_US(CLKS_PER_US)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .short_evt (short_evt),
    .long_evt  (long_evt),
    .short_en  (short_en),
    .long_en   (long_en),
    .short_req (short_req),
    .long_req  (long_req)
);

// File: tb/dual_interval_irq_bench.sv
`timescale 1ns/1ps
module dual_interval_irq_bench;
    localparam int unsigned DIV = 2;
    localparam int unsigned SL  = 4;
    localparam int unsigned LL  = 6;
    localparam int PS = DIV * (1 << SL);   // 32 edges
    localparam int PL = DIV * (1 << LL);   // 128 edges

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic short_en = 1'b0;
    logic long_en = 1'b0;
    logic short_req, long_req;

    int total = 0;
    int bad = 0;
    int e = 0;
    logic exp_s = 1'b0;
    logic exp_l = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_interval_irq #(.CLKS_PER_US(DIV), .SHORT_LOG2(SL), .LONG_LOG2(LL)) u_dual_interval_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_en  (short_en),
        .long_en   (long_en),
        .short_req (short_req),
        .long_req  (long_req)
    );

    // Reference model built from R3..R6: edges counted from 1 after reset release.
    always @(posedge clk) begin
        if (!rst_n) begin
            e     <= 0;
            exp_s <= 1'b0;
            exp_l <= 1'b0;
        end else begin
            e     <= e + 1;
            exp_s <= short_en ? (exp_s | (((e + 1) % PS) == 0)) : 1'b0;
            exp_l <= long_en  ? (exp_l | (((e + 1) % PL) == 0)) : 1'b0;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at edge %0d: actual=%0b expected=%0b", tag, e, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R3 R4 R5 R6 R9).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3_R5_R6 short model", short_req, exp_s);
            chk("R4_R9 long model", long_req, exp_l);
        end
    end

    task automatic goto(input int n);
        do @(negedge clk); while (e < n);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        short_en = 1'b1;
        long_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 short in reset", short_req, 1'b0);
        chk("R1 long in reset", long_req, 1'b0);
        short_en = 1'b0;
        long_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 short after release", short_req, 1'b0);
        chk("R1 long after release", long_req, 1'b0);
    endtask

    task automatic t_disarmed();
        goto(PL + 10);
        chk("R6 short stays low when disarmed", short_req, 1'b0);
        chk("R6 long stays low when disarmed", long_req, 1'b0);
    endtask

    task automatic t_short_phase();
        goto(150);
        short_en = 1'b1;
        goto(159);
        chk("R7 short before boundary", short_req, 1'b0);
        goto(160);
        chk("R7 R2 short at next boundary", short_req, 1'b1);
        goto(200);
        chk("R5 short sticky", short_req, 1'b1);
    endtask

    task automatic t_ack_rearm();
        short_en = 1'b0;
        goto(201);
        chk("R6 short cleared", short_req, 1'b0);
        short_en = 1'b1;
        goto(223);
        chk("R3 short not early", short_req, 1'b0);
        goto(224);
        chk("R3 short period", short_req, 1'b1);
    endtask

    task automatic t_both();
        goto(230);
        long_en = 1'b1;
        goto(240);
        short_en = 1'b0;
        goto(241);
        short_en = 1'b1;
        goto(255);
        chk("R8 short low before shared edge", short_req, 1'b0);
        chk("R4 long low before boundary", long_req, 1'b0);
        goto(256);
        chk("R8 short on shared edge", short_req, 1'b1);
        chk("R8 R4 long on shared edge", long_req, 1'b1);
    endtask

    task automatic t_independent();
        goto(260);
        long_en = 1'b0;
        goto(261);
        chk("R9 long acked", long_req, 1'b0);
        chk("R9 short untouched", short_req, 1'b1);
    endtask

    task automatic t_collision();
        short_en = 1'b0;
        goto(287);
        goto(288);
        chk("R6 clear wins on boundary", short_req, 1'b0);
        short_en = 1'b1;
        goto(289);
        chk("R6 no late raise", short_req, 1'b0);
        goto(320);
        chk("R3 short next boundary", short_req, 1'b1);
        chk("R9 long stays low", long_req, 1'b0);
    endtask

    initial begin
        t_reset();
        t_disarmed();
        t_short_phase();
        t_ack_rearm();
        t_both();
        t_independent();
        t_collision();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule